// File: doc/BRIEF.md
# Spread-Spectrum Charge Pulse Generator

This block drives the control bit of a capacitive sensing switch. The bit alternates between two phases. In the charge phase the raw bit is 0. In the no-charge phase the raw bit is 1. The charge phase has a fixed, programmable length. The no-charge phase has a programmable base length plus an extension that changes from one pulse to the next. Varying the pulse period in this way spreads the switching energy over a band of frequencies instead of concentrating it in one tone.

Two sources can supply the extension. The first is a variable-length linear feedback shift register whose state is masked by a weight. The second is a bounded up-down counter that moves by a programmable step every few charge cycles and turns around at its limits. A third mode turns dithering off. All phase lengths are counted in ticks of a prescaled clock. An inversion input flips the polarity of the bit at the output pin. A status output reports whether dithering is active.

Configuration inputs are expected to change only while `en` is low. Dropping `en` returns the block to its start state.

Top module: `ssc_pulse_gen`

## Requirements
- R1: While `en` is low, the raw bit is 0 (charge level) one clock later, and the dither sources return to their start state. When `en` rises again, the first no-charge pulse uses that start state.
- R2: Phase lengths are counted in ticks. One tick lasts `prescale`+1 system clocks, for every value from 0 to 255.
- R3: Every charge phase lasts (`chg_len`+1)·(`prescale`+1) clocks.
- R4: Every no-charge phase lasts (`base_len`+1+E)·(`prescale`+1) clocks, where E is the extension in force when that phase starts. In modes 2 and 3, E is 0.
- R5: `ctrl_bit` equals the raw bit XOR `invert`.
- R6: In mode 0 the register uses L bits, where L is `prbs_len` and codes 0 and 1 behave as 2. The register walks a maximal-length sequence of period 2^L−1 over nonzero states and advances once per charge phase. Its start state is `prbs_seed` masked to L bits, and an all-zero result is replaced by 1.
- R7: In mode 0, E is the register state ANDed bitwise with `prbs_weight`.
- R8: In mode 1 the counter starts at `ud_min` and counts upward. It updates once every R+1 charge phases, where R is `ud_repeat` and codes above 6 behave as 6. Each update moves it by `ud_step`. Moving upward, a value that would reach or pass the upper bound becomes the upper bound and the direction reverses. Moving downward, a value that would reach or pass `ud_min` becomes `ud_min` and the direction reverses.
- R9: In mode 1, E stays between `ud_min` and the upper bound. The upper bound is `ud_max`, or `ud_min` when `ud_max` is smaller.
- R10: `dither_on` is 1 exactly when `en` is high and `mode` is 0 or 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| en | input | 1 | Run enable; low holds the block cleared |
| prescale | input | 8 | Tick divider, one tick per value+1 clocks |
| chg_len | input | 4 | Charge phase length code (ticks−1) |
| base_len | input | 4 | No-charge base length code (ticks−1) |
| mode | input | 2 | 0 shift register, 1 up-down counter, 2 and 3 fixed |
| invert | input | 1 | Output polarity flip |
| prbs_len | input | 4 | Shift register length code |
| prbs_seed | input | 16 | Shift register start value |
| prbs_weight | input | 16 | Mask applied to the register state |
| ud_repeat | input | 5 | Charge phases per counter update, minus one |
| ud_step | input | 3 | Counter step size |
| ud_min | input | 4 | Lower counter bound and start value |
| ud_max | input | 6 | Upper counter bound |
| ctrl_bit | output | 1 | Switch control bit after polarity flip |
| dither_on | output | 1 | High while dithering is active |

## Verification
The hardest states to reach are the turnaround points of the up-down counter. Three of them matter: the clamp to the upper bound when a step would overshoot, the clamp at the lower bound on the way down, and the case where `ud_max` is below `ud_min`. They are only visible as a sequence of no-charge widths. The bench runs long pulse trains and converts each measured width back into an extension. It then compares each extension with a small bounce model built from the requirements. For the shift register, the bench checks the properties instead of a fixed list: all nonzero values appear once in one period, and the sequence then repeats.

// File: rtl/ssc_pkg.sv
package ssc_pkg;

    typedef enum logic {
        PH_CHARGE = 1'b0,
        PH_NOCHG  = 1'b1
    } phase_e;

    typedef enum logic [1:0] {
        DM_PRBS   = 2'd0,
        DM_UPDOWN = 2'd1,
        DM_FIXED  = 2'd2,
        DM_SPARE  = 2'd3
    } dither_mode_e;

    localparam int UD_REPEAT_CAP = 6;
    localparam int PRBS_MIN_LEN  = 2;

    // Feedback tap mask for a maximal-length XOR register of n bits.
    // Bit k-1 of the result is set when stage k feeds back.
    function automatic logic [15:0] prbs_taps(input logic [3:0] n);
        logic [15:0] t;
        case (n)
            4'd2:    t = 16'h0003;
            4'd3:    t = 16'h0006;
            4'd4:    t = 16'h000C;
            4'd5:    t = 16'h0014;
            4'd6:    t = 16'h0030;
            4'd7:    t = 16'h0060;
            4'd8:    t = 16'h00B8;
            4'd9:    t = 16'h0110;
            4'd10:   t = 16'h0240;
            4'd11:   t = 16'h0500;
            4'd12:   t = 16'h0829;
            4'd13:   t = 16'h100D;
            4'd14:   t = 16'h2015;
            4'd15:   t = 16'h6000;
            default: t = 16'h0003;
        endcase
        return t;
    endfunction

endpackage

// File: rtl/ssc_prescaler.sv
module ssc_prescaler #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic [DIV_W-1:0] div,
    output logic             tick
);
    logic [DIV_W-1:0] cnt_d, cnt_q;

    always_comb begin
        tick = !clr && (cnt_q >= div);
        if (clr || tick) begin
            cnt_d = '0;
        end else begin
            cnt_d = cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end
endmodule

// File: rtl/ssc_prbs.sv
module ssc_prbs
    import ssc_pkg::*;
#(
    parameter int ST_W  = 16,
    parameter int LEN_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             adv,
    input  logic [LEN_W-1:0] len_code,
    input  logic [ST_W-1:0]  seed,
    input  logic [ST_W-1:0]  weight,
    output logic [ST_W-1:0]  ext
);
    logic [ST_W-1:0]  st_d, st_q;
    logic [LEN_W-1:0] eff_len;
    logic [ST_W-1:0]  len_mask;
    logic [ST_W-1:0]  taps;
    logic [ST_W-1:0]  seed_m;
    logic [ST_W-1:0]  load_val;
    logic [ST_W-1:0]  shifted;
    logic             fb;

    always_comb begin
        // Length codes below the minimum act as the minimum length.
        eff_len = (int'(len_code) < PRBS_MIN_LEN) ? LEN_W'(PRBS_MIN_LEN) : len_code;
        for (int i = 0; i < ST_W; i++) begin
            len_mask[i] = (i < int'(eff_len));
        end
        taps     = ST_W'(prbs_taps(eff_len[3:0]));
        seed_m   = seed & len_mask;
        load_val = (seed_m == '0) ? ST_W'(1) : seed_m;
        fb       = ^(st_q & taps);
        shifted  = ({st_q[ST_W-2:0], fb}) & len_mask;

        if (clr) begin
            st_d = load_val;
        end else if (adv) begin
            st_d = shifted;
        end else begin
            st_d = st_q;
        end
        ext = st_q & weight;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= ST_W'(1);
        end else begin
            st_q <= st_d;
        end
    end
endmodule

// File: rtl/ssc_updown.sv
module ssc_updown
    import ssc_pkg::*;
#(
    parameter int VAL_W  = 6,
    parameter int STEP_W = 3,
    parameter int REP_W  = 5,
    parameter int MIN_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              adv,
    input  logic [REP_W-1:0]  rep,
    input  logic [STEP_W-1:0] step,
    input  logic [MIN_W-1:0]  min_code,
    input  logic [VAL_W-1:0]  max_code,
    output logic [VAL_W-1:0]  ext
);
    typedef struct packed {
        logic [VAL_W-1:0] val;
        logic             down;
        logic [REP_W-1:0] rc;
    } ud_state_t;

    ud_state_t        s_d, s_q;
    logic [VAL_W-1:0] lo, hi;
    logic [REP_W-1:0] rep_eff;
    logic [VAL_W:0]   up_sum;
    logic [VAL_W:0]   lo_plus;

    always_comb begin
        lo      = VAL_W'(min_code);
        hi      = (max_code < lo) ? lo : max_code;
        rep_eff = (int'(rep) > UD_REPEAT_CAP) ? REP_W'(UD_REPEAT_CAP) : rep;
        up_sum  = {1'b0, s_q.val} + (VAL_W+1)'(step);
        lo_plus = {1'b0, lo} + (VAL_W+1)'(step);

        s_d = s_q;
        if (clr) begin
            s_d.val  = lo;
            s_d.down = 1'b0;
            s_d.rc   = '0;
        end else if (adv) begin
            if (s_q.rc >= rep_eff) begin
                s_d.rc = '0;
                if (!s_q.down) begin
                    if (up_sum >= {1'b0, hi}) begin
                        s_d.val  = hi;
                        s_d.down = 1'b1;
                    end else begin
                        s_d.val = up_sum[VAL_W-1:0];
                    end
                end else begin
                    if ({1'b0, s_q.val} <= lo_plus) begin
                        s_d.val  = lo;
                        s_d.down = 1'b0;
                    end else begin
                        s_d.val = s_q.val - VAL_W'(step);
                    end
                end
            end else begin
                s_d.rc = s_q.rc + 1'b1;
            end
        end
        ext = s_q.val;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end
endmodule

// File: rtl/ssc_phase_seq.sv
module ssc_phase_seq
    import ssc_pkg::*;
#(
    parameter int CHG_W  = 4,
    parameter int BASE_W = 4,
    parameter int EXT_W  = 16,
    parameter int TERM_W = EXT_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              tick,
    input  logic [CHG_W-1:0]  chg_len,
    input  logic [BASE_W-1:0] base_len,
    input  logic [EXT_W-1:0]  ext,
    output logic              raw,
    output logic              chg_done
);
    typedef struct packed {
        phase_e            phase;
        logic [TERM_W-1:0] cnt;
        logic [TERM_W-1:0] term;
    } seq_state_t;

    seq_state_t s_d, s_q;

    always_comb begin
        s_d      = s_q;
        chg_done = 1'b0;
        if (clr) begin
            s_d.phase = PH_CHARGE;
            s_d.cnt   = '0;
            s_d.term  = '0;
        end else if (tick) begin
            case (s_q.phase)
                PH_CHARGE: begin
                    if (s_q.cnt == TERM_W'(chg_len)) begin
                        // Terminal count of the coming no-charge phase is frozen here.
                        s_d.phase = PH_NOCHG;
                        s_d.cnt   = '0;
                        s_d.term  = TERM_W'(base_len) + TERM_W'(ext);
                        chg_done  = 1'b1;
                    end else begin
                        s_d.cnt = s_q.cnt + 1'b1;
                    end
                end
                default: begin
                    if (s_q.cnt == s_q.term) begin
                        s_d.phase = PH_CHARGE;
                        s_d.cnt   = '0;
                    end else begin
                        s_d.cnt = s_q.cnt + 1'b1;
                    end
                end
            endcase
        end
        raw = (s_q.phase == PH_NOCHG);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '{phase: PH_CHARGE, cnt: '0, term: '0};
        end else begin
            s_q <= s_d;
        end
    end
endmodule

// File: rtl/ssc_pulse_gen.sv
module ssc_pulse_gen
    import ssc_pkg::*;
#(
    parameter int PRE_W  = 8,
    parameter int CHG_W  = 4,
    parameter int BASE_W = 4,
    parameter int PLEN_W = 4,
    parameter int SEED_W = 16,
    parameter int REP_W  = 5,
    parameter int STEP_W = 3,
    parameter int MIN_W  = 4,
    parameter int UD_W   = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic [PRE_W-1:0]  prescale,
    input  logic [CHG_W-1:0]  chg_len,
    input  logic [BASE_W-1:0] base_len,
    input  logic [1:0]        mode,
    input  logic              invert,
    input  logic [PLEN_W-1:0] prbs_len,
    input  logic [SEED_W-1:0] prbs_seed,
    input  logic [SEED_W-1:0] prbs_weight,
    input  logic [REP_W-1:0]  ud_repeat,
    input  logic [STEP_W-1:0] ud_step,
    input  logic [MIN_W-1:0]  ud_min,
    input  logic [UD_W-1:0]   ud_max,
    output logic              ctrl_bit,
    output logic              dither_on
);
    localparam int EXT_W  = (SEED_W > UD_W) ? SEED_W : UD_W;
    localparam int TERM_W = EXT_W + 1;

    logic              clr;
    logic              tick;
    logic              chg_done;
    logic              raw;
    logic [SEED_W-1:0] prbs_ext;
    logic [UD_W-1:0]   ud_ext;
    logic [EXT_W-1:0]  ext_sel;
    dither_mode_e      mode_e;

    assign clr    = !en;
    assign mode_e = dither_mode_e'(mode);

    ssc_prescaler #(.DIV_W(PRE_W)) u_presc (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (clr),
        .div   (prescale),
        .tick  (tick)
    );

    ssc_prbs #(.ST_W(SEED_W), .LEN_W(PLEN_W)) u_prbs (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (clr),
        .adv      (chg_done),
        .len_code (prbs_len),
        .seed     (prbs_seed),
        .weight   (prbs_weight),
        .ext      (prbs_ext)
    );

    ssc_updown #(.VAL_W(UD_W), .STEP_W(STEP_W), .REP_W(REP_W), .MIN_W(MIN_W)) u_updown (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (clr),
        .adv      (chg_done),
        .rep      (ud_repeat),
        .step     (ud_step),
        .min_code (ud_min),
        .max_code (ud_max),
        .ext      (ud_ext)
    );

    always_comb begin
        case (mode_e)
            DM_PRBS:   ext_sel = EXT_W'(prbs_ext);
            DM_UPDOWN: ext_sel = EXT_W'(ud_ext);
            default:   ext_sel = '0;
        endcase
    end

    ssc_phase_seq #(.CHG_W(CHG_W), .BASE_W(BASE_W), .EXT_W(EXT_W), .TERM_W(TERM_W)) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (clr),
        .tick     (tick),
        .chg_len  (chg_len),
        .base_len (base_len),
        .ext      (ext_sel),
        .raw      (raw),
        .chg_done (chg_done)
    );

    assign ctrl_bit  = raw ^ invert;
    assign dither_on = en && ((mode_e == DM_PRBS) || (mode_e == DM_UPDOWN));
endmodule

// File: rtl/ssc_pulse_gen_chk.sv
module ssc_pulse_gen_chk #(
    parameter int PRE_W  = 8,
    parameter int CHG_W  = 4,
    parameter int BASE_W = 4,
    parameter int MIN_W  = 4,
    parameter int UD_W   = 6
) (
    input logic              clk,
    input logic              rst_n,
    input logic              en,
    input logic [PRE_W-1:0]  prescale,
    input logic [CHG_W-1:0]  chg_len,
    input logic [BASE_W-1:0] base_len,
    input logic [1:0]        mode,
    input logic              invert,
    input logic [MIN_W-1:0]  ud_min,
    input logic [UD_W-1:0]   ud_max,
    input logic              ctrl_bit,
    input logic              dither_on
);
    logic raw;
    logic prev_q;
    logic valid_q;
    int   run_q;
    int   div, lo, hi;
    logic edge_seen;

    assign raw       = ctrl_bit ^ invert;
    assign div       = int'(prescale) + 1;
    assign lo        = int'(ud_min);
    assign hi        = (int'(ud_max) < lo) ? lo : int'(ud_max);
    assign edge_seen = en && valid_q && (raw != prev_q);

    // Run-length monitor: run_q holds how many samples the previous level lasted.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev_q  <= 1'b0;
            valid_q <= 1'b0;
            run_q   <= 0;
        end else if (!en) begin
            prev_q  <= raw;
            valid_q <= 1'b0;
            run_q   <= 0;
        end else if (raw != prev_q) begin
            prev_q  <= raw;
            valid_q <= 1'b1;
            run_q   <= 1;
        end else begin
            run_q <= run_q + 1;
        end
    end

    a_r1_idle_level: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> (ctrl_bit == invert));

    a_r3_charge_width: assert property (@(posedge clk) disable iff (!rst_n)
        (edge_seen && !prev_q) |-> (run_q == (int'(chg_len) + 1) * div));

    a_r4_fixed_nochg_width: assert property (@(posedge clk) disable iff (!rst_n)
        (edge_seen && prev_q && mode[1]) |-> (run_q == (int'(base_len) + 1) * div));

    a_r9_ud_bounds: assert property (@(posedge clk) disable iff (!rst_n)
        (edge_seen && prev_q && mode == 2'd1) |->
            ((run_q >= (lo + 1 + int'(base_len)) * div) &&
             (run_q <= (hi + 1 + int'(base_len)) * div)));

    a_r10_flag_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (!en || mode[1]) |-> !dither_on);
endmodule

bind ssc_pulse_gen ssc_pulse_gen_chk #(
    .PRE_W(PRE_W), .CHG_W(CHG_W), .BASE_W(BASE_W), .MIN_W(MIN_W), .UD_W(UD_W)
) u_chk (.*);

// File: tb/ssc_pulse_gen_bench.sv
`timescale 1ns/1ps
module ssc_pulse_gen_bench;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        en;
    logic [7:0]  prescale;
    logic [3:0]  chg_len, base_len;
    logic [1:0]  mode;
    logic        invert;
    logic [3:0]  prbs_len;
    logic [15:0] prbs_seed, prbs_weight;
    logic [4:0]  ud_repeat;
    logic [2:0]  ud_step;
    logic [3:0]  ud_min;
    logic [5:0]  ud_max;
    logic        ctrl_bit, dither_on;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    ssc_pulse_gen u_ssc_pulse_gen (.*);

    typedef struct packed {
        logic [7:0]  pre;
        logic [3:0]  chg;
        logic [3:0]  base;
        logic [1:0]  md;
        logic        inv;
        logic [3:0]  plen;
        logic [15:0] seed;
        logic [15:0] weight;
        logic [4:0]  rep;
        logic [2:0]  step;
        logic [3:0]  mn;
        logic [5:0]  mx;
        logic [15:0] exp_ch;
        logic [15:0] exp_nc;
        logic        exp_flag;
    } vec_t;

    localparam int NVEC = 8;
    localparam vec_t VECS [NVEC] = '{
        '{8'd0, 4'd3,  4'd2,  2'd2, 1'b0, 4'd0, 16'h0000, 16'h0000, 5'd0, 3'd0, 4'd0, 6'd0,  16'd4,   16'd3,   1'b0},
        '{8'd1, 4'd0,  4'd0,  2'd2, 1'b1, 4'd0, 16'h0000, 16'h0000, 5'd0, 3'd0, 4'd0, 6'd0,  16'd2,   16'd2,   1'b0},
        '{8'd3, 4'd5,  4'd1,  2'd0, 1'b0, 4'd4, 16'h0005, 16'hFFFF, 5'd0, 3'd0, 4'd0, 6'd0,  16'd24,  16'd28,  1'b1},
        '{8'd0, 4'd1,  4'd3,  2'd1, 1'b0, 4'd0, 16'h0000, 16'h0000, 5'd0, 3'd2, 4'd4, 6'd10, 16'd2,   16'd8,   1'b1},
        '{8'd0, 4'd2,  4'd0,  2'd0, 1'b1, 4'd3, 16'h00F8, 16'hFFFF, 5'd0, 3'd0, 4'd0, 6'd0,  16'd3,   16'd2,   1'b1},
        '{8'd7, 4'd15, 4'd15, 2'd2, 1'b0, 4'd0, 16'h0000, 16'h0000, 5'd0, 3'd0, 4'd0, 6'd0,  16'd128, 16'd128, 1'b0},
        '{8'd0, 4'd0,  4'd5,  2'd3, 1'b0, 4'd0, 16'h0000, 16'h0000, 5'd0, 3'd0, 4'd0, 6'd0,  16'd1,   16'd6,   1'b0},
        '{8'd0, 4'd0,  4'd0,  2'd0, 1'b0, 4'd8, 16'h00A5, 16'h000F, 5'd0, 3'd0, 4'd0, 6'd0,  16'd1,   16'd6,   1'b1}
    };

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic logic raw_now();
        return ctrl_bit ^ invert;
    endfunction

    task automatic sync_rise();
        while (raw_now() != 1'b0) @(negedge clk);
        while (raw_now() != 1'b1) @(negedge clk);
    endtask

    task automatic run_pair(output int nc, output int ch);
        nc = 0;
        ch = 0;
        while (raw_now() == 1'b1) begin nc++; @(negedge clk); end
        while (raw_now() == 1'b0) begin ch++; @(negedge clk); end
    endtask

    task automatic apply(input vec_t v);
        @(negedge clk);
        en          = 1'b0;
        prescale    = v.pre;
        chg_len     = v.chg;
        base_len    = v.base;
        mode        = v.md;
        invert      = v.inv;
        prbs_len    = v.plen;
        prbs_seed   = v.seed;
        prbs_weight = v.weight;
        ud_repeat   = v.rep;
        ud_step     = v.step;
        ud_min      = v.mn;
        ud_max      = v.mx;
        repeat (3) @(negedge clk);
    endtask

    function automatic vec_t mk(input logic [7:0] pre, input logic [3:0] chg, input logic [3:0] base,
                                input logic [1:0] md, input logic [3:0] plen, input logic [15:0] seed,
                                input logic [15:0] weight, input logic [4:0] rep, input logic [2:0] step,
                                input logic [3:0] mn, input logic [5:0] mx);
        vec_t v;
        v = '0;
        v.pre = pre; v.chg = chg; v.base = base; v.md = md; v.plen = plen;
        v.seed = seed; v.weight = weight; v.rep = rep; v.step = step; v.mn = mn; v.mx = mx;
        return v;
    endfunction

    // Up-down extension in force for no-charge pulse number n (n = 0 first).
    function automatic int ud_model(input int n, input int rep, input int step, input int mn, input int mx);
        int hi, r, v, rc;
        bit down;
        hi = (mx < mn) ? mn : mx;
        r  = (rep > 6) ? 6 : rep;
        v = mn; rc = 0; down = 0;
        for (int i = 0; i < n; i++) begin
            if (rc >= r) begin
                rc = 0;
                if (!down) begin
                    if (v + step >= hi) begin v = hi; down = 1; end
                    else v = v + step;
                end else begin
                    if (v <= mn + step) begin v = mn; down = 0; end
                    else v = v - step;
                end
            end else begin
                rc++;
            end
        end
        return v;
    endfunction

    task automatic ud_sequence(input int rep, input int step, input int mn, input int mx,
                               input int npulse, input string req);
        int nc, ch;
        apply(mk(8'd0, 4'd0, 4'd0, 2'd1, 4'd0, 16'h0, 16'h0, 5'(rep), 3'(step), 4'(mn), 6'(mx)));
        en = 1'b1;
        sync_rise();
        for (int i = 0; i < npulse; i++) begin
            run_pair(nc, ch);
            chk(nc - 1 == ud_model(i, rep, step, mn, mx), req, nc - 1, ud_model(i, rep, step, mn, mx));
        end
    endtask

    task automatic prbs_period(input int code, input int len, input string req);
        int nc, ch, n, first, distinct, ok_range;
        bit seen [32];
        n = (1 << len) - 1;
        foreach (seen[k]) seen[k] = 1'b0;
        apply(mk(8'd0, 4'd0, 4'd0, 2'd0, 4'(code), 16'h0001, 16'hFFFF, 5'd0, 3'd0, 4'd0, 6'd0));
        en = 1'b1;
        sync_rise();
        distinct = 0;
        ok_range = 1;
        first = 0;
        for (int i = 0; i < n; i++) begin
            run_pair(nc, ch);
            if (i == 0) first = nc - 1;
            if (nc - 1 < 1 || nc - 1 > n) ok_range = 0;
            else if (!seen[nc - 1]) begin seen[nc - 1] = 1'b1; distinct++; end
        end
        run_pair(nc, ch);
        chk(ok_range == 1, req, ok_range, 1);
        chk(distinct == n, req, distinct, n);
        chk(nc - 1 == first, req, nc - 1, first);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin : main
        int nc, ch;
        rst_n = 1'b0;
        apply(mk(8'd0, 4'd0, 4'd0, 2'd2, 4'd0, 16'h0, 16'h0, 5'd0, 3'd0, 4'd0, 6'd0));
        // Reset state: disabled, charge level, no dithering (R1, R10)
        chk(ctrl_bit == 1'b0, "R1 reset level", ctrl_bit, 0);
        chk(dither_on == 1'b0, "R10 reset flag", dither_on, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // Table walk: widths of first no-charge and following charge phase.
        for (int i = 0; i < NVEC; i++) begin
            apply(VECS[i]);
            chk(ctrl_bit == VECS[i].inv, "R1/R5 idle polarity", ctrl_bit, VECS[i].inv);
            chk(dither_on == 1'b0, "R10 flag while disabled", dither_on, 0);
            en = 1'b1;
            sync_rise();
            chk(dither_on == VECS[i].exp_flag, "R10 flag", dither_on, VECS[i].exp_flag);
            chk(ctrl_bit == !VECS[i].inv, "R5 no-charge polarity", ctrl_bit, !VECS[i].inv);
            run_pair(nc, ch);
            chk(nc == int'(VECS[i].exp_nc), "R4/R2/R6/R7 no-charge width", nc, VECS[i].exp_nc);
            chk(ch == int'(VECS[i].exp_ch), "R3/R2 charge width", ch, VECS[i].exp_ch);
        end

        // R8: bounce between min and max with repeat and overshoot clamp.
        ud_sequence(1, 3, 2, 9, 14, "R8 bounce");
        // R8: repeat codes above 6 behave as 6.
        ud_sequence(20, 1, 0, 20, 9, "R8 repeat cap");
        // R9: max below min pins the extension at min.
        ud_sequence(0, 1, 5, 2, 5, "R9 inverted bounds");

        // R6: maximal period for 4 bits, and code 0 behaving as 2 bits.
        prbs_period(4, 4, "R6 period len4");
        prbs_period(0, 2, "R6 period code0");

        // R7: single-bit weight leaves only 0 or 2 as extension.
        begin
            int seen0, seen2, bad;
            seen0 = 0; seen2 = 0; bad = 0;
            apply(mk(8'd0, 4'd0, 4'd0, 2'd0, 4'd5, 16'h0013, 16'h0002, 5'd0, 3'd0, 4'd0, 6'd0));
            en = 1'b1;
            sync_rise();
            for (int i = 0; i < 31; i++) begin
                run_pair(nc, ch);
                if (nc - 1 == 0) seen0++;
                else if (nc - 1 == 2) seen2++;
                else bad++;
            end
            chk(bad == 0, "R7 weight mask", bad, 0);
            chk(seen0 > 0 && seen2 > 0, "R7 both values", seen0 * 100 + seen2, 1);
        end

        // R1: disable mid-pulse, then restart from the seed state.
        apply(mk(8'd0, 4'd1, 4'd2, 2'd0, 4'd4, 16'h0005, 16'hFFFF, 5'd0, 3'd0, 4'd0, 6'd0));
        en = 1'b1;
        sync_rise();
        run_pair(nc, ch);
        run_pair(nc, ch);
        @(negedge clk);
        en = 1'b0;
        repeat (2) @(negedge clk);
        chk(ctrl_bit == 1'b0, "R1 drop to charge", ctrl_bit, 0);
        en = 1'b1;
        sync_rise();
        run_pair(nc, ch);
        chk(nc == 8, "R1 restart from seed", nc, 8);
        chk(ch == 2, "R3 charge after restart", ch, 2);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule